// File: doc/BRIEF.md
# Periodic DRAM Refresh Requester

This block paces DRAM refresh. A down-counter runs on the internal processor clock and reloads from a 9-bit period value. Each time it expires, the block marks a refresh as owed and raises a request. The bus interface unit answers that request with a memory-read refresh cycle and acknowledges it. The counter has no notion of clock frequency. Software must write a new period and pulse the load input whenever the processor clock rate changes, for example on entry to a power-save mode.

The block also owns the bus-hold handshake with an external master. While no refresh is owed, a hold request is granted one cycle after it is seen. When a refresh falls due while the bus is lent out, the grant is taken back. The request is then held back until the external master has kept its hold request low for a full clock. While a refresh is outstanding, new hold requests wait. The grant returns once the refresh has been acknowledged.

Top module: `refresh_req_gen`

## Requirements
- R1: With the bus free, the first rising edge of `rfsh_req` comes on the (P+2)th clock edge, counting the first edge that samples `cfg_enable` high. P is `cfg_period`, held stable while enabled. When each request is acknowledged in the cycle it is seen, later requests rise every max(P+1, 2) cycles.
- R2: A one-cycle `cfg_load` pulse reloads the counter from `cfg_period` (value Q) and raises no request. The next request rises Q+2 edges after the edge that sampled the pulse. Later requests then follow every Q+1 cycles.
- R3: While `cfg_enable` is sampled low, `rfsh_req` is low from the next edge on, and any owed refresh is discarded. Enabling again restarts the full interval of R1.
- R4: `rfsh_req` stays high until `rfsh_ack` is sampled high. Expiries that occur meanwhile are merged into the outstanding request. One acknowledge clears them all, and the next request follows the next expiry.
- R5: If an expiry lands on the same edge as the acknowledge, the new refresh is kept. `rfsh_req` is then low for exactly one cycle and high again on the following edge.
- R6: With no refresh owed, `hold_ack` rises on the edge after `hold_req` is sampled high. It falls on the edge after `hold_req` is sampled low. This holds while the block is disabled too.
- R7: When a refresh becomes owed while `hold_ack` is high, `hold_ack` is deasserted on the next edge. `rfsh_req` stays low for as long as `hold_req` remains high.
- R8: After `hold_req` is sampled low, `rfsh_req` rises on the second edge and not on the first, so the hold request has been low for at least one whole clock.
- R9: `hold_ack` and `rfsh_req` are never high together. If `hold_req` is high while a refresh is acknowledged, `hold_ack` rises on the edge after the acknowledge edge.
- R10: While `rst_n` is low, and after its release, `rfsh_req` and `hold_ack` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Refresh enable; low clears owed refresh and reloads counter |
| cfg_period | input | 9 | Interval reload value P |
| cfg_load | input | 1 | Reload counter from `cfg_period` (after clock-rate change) |
| hold_req | input | 1 | External master bus-hold request |
| rfsh_ack | input | 1 | Bus interface accepted the refresh cycle |
| hold_ack | output | 1 | Bus granted to external master |
| rfsh_req | output | 1 | Refresh memory-read request to bus interface |

## Verification
Counter expiry and the bus interface's acknowledge can fall on the same clock edge. The bench provokes this by holding a request unacknowledged and timing the acknowledge exactly onto the edge where the next expiry is registered. It then expects `rfsh_req` to drop for one cycle and return at once. It also times an acknowledge just off that edge and expects the merged request to clear until the following expiry. A second pair of events that can meet is a new hold request arriving while a refresh is still outstanding. Here the bench expects the grant to be withheld until the edge after the acknowledge.

// File: rtl/rr_pkg.sv
package rr_pkg;
  // ownership of the bus as seen by this block
  typedef enum logic [1:0] {
    BUS_IDLE = 2'd0,  // processor side owns the bus, nothing requested
    BUS_LENT = 2'd1,  // external master holds the bus
    BUS_RFSH = 2'd2   // refresh request presented to the bus interface
  } bus_state_e;
endpackage

// File: rtl/rr_interval.sv
module rr_interval #(
  parameter int PERIOD_W = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable_i,
  input  logic                load_i,
  input  logic [PERIOD_W-1:0] period_i,
  output logic                expire_o
);
  localparam logic [PERIOD_W-1:0] CNT_ZERO = '0;
  localparam logic [PERIOD_W-1:0] CNT_ONE  = {{(PERIOD_W-1){1'b0}}, 1'b1};

  logic [PERIOD_W-1:0] cnt_q, cnt_d;
  logic                run;

  always_comb begin
    run      = enable_i && !load_i;
    expire_o = run && (cnt_q == CNT_ZERO);
    if (!run || expire_o) cnt_d = period_i;
    else                  cnt_d = cnt_q - CNT_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= CNT_ZERO;
    else        cnt_q <= cnt_d;
  end

  // R1: an expiry starts a fresh interval from the period value
  assert_expiry_reload_R1: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> (cnt_q == $past(period_i)));

  // R2: a load pulse never produces an expiry in its own cycle
  assert_load_no_expiry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> !expire_o);
endmodule

// File: rtl/rr_bus_arb.sv
module rr_bus_arb
  import rr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enable_i,
  input  logic owed_i,
  input  logic hold_req_i,
  input  logic done_i,
  output logic hold_ack_o,
  output logic rfsh_req_o
);
  bus_state_e state_q, state_d;
  logic       quiet_q;  // hold request was low at the previous edge

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      BUS_IDLE: begin
        if (enable_i && owed_i && quiet_q) state_d = BUS_RFSH;
        else if (hold_req_i && !owed_i)    state_d = BUS_LENT;
      end
      BUS_LENT: begin
        if (owed_i || !hold_req_i) state_d = BUS_IDLE;
      end
      BUS_RFSH: begin
        if (done_i || !enable_i) state_d = BUS_IDLE;
      end
      default: state_d = BUS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= BUS_IDLE;
      quiet_q <= 1'b0;
    end else begin
      state_q <= state_d;
      quiet_q <= !hold_req_i;
    end
  end

  assign hold_ack_o = (state_q == BUS_LENT);
  assign rfsh_req_o = (state_q == BUS_RFSH);

  // R7: an owed refresh takes the bus back on the next edge
  assert_reclaim_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (owed_i && hold_ack_o) |=> !hold_ack_o);

  // R8: a request only rises after hold request was low a full clock
  assert_release_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rfsh_req_o) |-> !$past(hold_req_i, 2));
endmodule

// File: rtl/refresh_req_gen.sv
module refresh_req_gen #(
  parameter int PERIOD_W    = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_enable,
  input  logic [PERIOD_W-1:0] cfg_period,
  input  logic                cfg_load,
  input  logic                hold_req,
  input  logic                rfsh_ack,
  output logic                hold_ack,
  output logic                rfsh_req
);
  logic [SYNC_STAGES-1:0] rst_pipe_q;
  logic                   rst_sync_n;
  logic                   expire;
  logic                   owed_q, owed_d;

  // reset asserts at once, releases on a clock edge
  generate
    if (SYNC_STAGES == 1) begin : g_sync_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_pipe_q <= '0;
        else        rst_pipe_q <= 1'b1;
      end
    end else begin : g_sync_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_pipe_q <= '0;
        else        rst_pipe_q <= {rst_pipe_q[SYNC_STAGES-2:0], 1'b1};
      end
    end
  endgenerate
  assign rst_sync_n = rst_pipe_q[SYNC_STAGES-1];

  rr_interval #(.PERIOD_W(PERIOD_W)) u_interval (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .enable_i (cfg_enable),
    .load_i   (cfg_load),
    .period_i (cfg_period),
    .expire_o (expire)
  );

  // owed-refresh flag: expiry wins over a simultaneous acknowledge
  always_comb begin
    owed_d = owed_q;
    if (!cfg_enable)               owed_d = 1'b0;
    else if (expire)               owed_d = 1'b1;
    else if (rfsh_ack && rfsh_req) owed_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) owed_q <= 1'b0;
    else             owed_q <= owed_d;
  end

  rr_bus_arb u_arb (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .enable_i   (cfg_enable),
    .owed_i     (owed_q),
    .hold_req_i (hold_req),
    .done_i     (rfsh_ack),
    .hold_ack_o (hold_ack),
    .rfsh_req_o (rfsh_req)
  );

  // R3: disabled means no request from the next edge
  assert_off_silent_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cfg_enable |=> !rfsh_req);

  // R4: a request only drops through acknowledge or disable
  assert_req_held_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(rfsh_req) |-> ($past(rfsh_ack) || !$past(cfg_enable)));

  // R9: the bus is never granted to both sides
  assert_bus_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(hold_ack && rfsh_req));

  // R10: outputs quiet while reset is held
  always_comb begin
    if (!rst_sync_n) assert_reset_quiet_R10: assert (!hold_ack && !rfsh_req);
  end
endmodule

// File: tb/refresh_req_gen_test.sv
module refresh_req_gen_test;
  localparam int PW = 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_enable = 1'b0;
  logic          cfg_load = 1'b0;
  logic          hold_req = 1'b0;
  logic          rfsh_ack = 1'b0;
  logic [PW-1:0] cfg_period = '0;
  logic          hold_ack, rfsh_req;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  refresh_req_gen #(.PERIOD_W(PW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_period(cfg_period),
    .cfg_load(cfg_load), .hold_req(hold_req), .rfsh_ack(rfsh_ack),
    .hold_ack(hold_ack), .rfsh_req(rfsh_req)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected <150000 cycles", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_high(output int k, input int limit);
    k = 0;
    do begin cyc(); k++; end while (!rfsh_req && k < limit);
  endtask

  task automatic ack_gap(output int k, input int limit);
    rfsh_ack = 1'b1; cyc(); rfsh_ack = 1'b0; k = 1;
    while (!rfsh_req && k < limit) begin cyc(); k++; end
  endtask

  task automatic start(input int p);
    cfg_enable = 1'b0; cyc();
    chk("R3 low while disabled", int'(rfsh_req), 0);
    cfg_period = PW'(p); cyc();
    cfg_enable = 1'b1;
  endtask

  task automatic run_period(input int p);
    int k;
    start(p);
    wait_high(k, 1200);
    chk($sformatf("R1 first request P=%0d", p), k, p + 2);
    for (int i = 0; i < 3; i++) begin
      ack_gap(k, 1200);
      chk($sformatf("R1 spacing P=%0d", p), k, (p == 0) ? 2 : p + 1);
    end
    cfg_enable = 1'b0; cyc();
  endtask

  initial begin
    int k;
    int t;
    cyc(); cyc();
    chk("R10 reset rfsh_req", int'(rfsh_req), 0);
    chk("R10 reset hold_ack", int'(hold_ack), 0);
    rst_n = 1'b1;
    repeat (4) cyc();
    chk("R10 after reset", int'(rfsh_req | hold_ack), 0);

    // R1 sweep over the period
    for (int p = 0; p <= 24; p++) run_period(p);
    run_period(511);

    // R6 hold grant with nothing owed (block disabled)
    cfg_enable = 1'b0; cyc();
    hold_req = 1'b1;
    chk("R6 no grant before edge", int'(hold_ack), 0);
    cyc();
    chk("R6 grant one edge later", int'(hold_ack), 1);
    hold_req = 1'b0; cyc();
    chk("R6 release one edge later", int'(hold_ack), 0);

    // R3 disable drops an unacknowledged request
    start(6);
    wait_high(k, 100);
    chk("R3 setup", k, 8);
    cfg_enable = 1'b0; cyc();
    chk("R3 request dropped", int'(rfsh_req), 0);
    t = 0;
    for (int i = 0; i < 20; i++) begin cyc(); t += int'(rfsh_req); end
    chk("R3 silent while disabled", t, 0);
    cfg_enable = 1'b1;
    wait_high(k, 100);
    chk("R3 full interval after re-enable", k, 8);
    cfg_enable = 1'b0; cyc();

    // R4 merge of expiries during an outstanding request (P=5)
    start(5);
    wait_high(k, 100);
    t = 0;
    for (int i = 0; i < 18; i++) begin cyc(); t += int'(rfsh_req); end
    chk("R4 held until acknowledge", t, 18);
    rfsh_ack = 1'b1; cyc(); rfsh_ack = 1'b0;
    chk("R4 cleared by one acknowledge", int'(rfsh_req), 0);
    k = 0;
    while (!rfsh_req && k < 100) begin cyc(); k++; end
    chk("R4 next request at next expiry", k, 4 * 6 - 19);
    cfg_enable = 1'b0; cyc();

    // R5 acknowledge on the same edge as an expiry (P=5)
    start(5);
    wait_high(k, 100);
    repeat (10) cyc();
    rfsh_ack = 1'b1; cyc(); rfsh_ack = 1'b0;
    chk("R5 low for one cycle", int'(rfsh_req), 0);
    cyc();
    chk("R5 back high next edge", int'(rfsh_req), 1);
    cfg_enable = 1'b0; cyc();

    // R2 reload after a clock-rate change
    start(30);
    wait_high(k, 100);
    chk("R2 setup", k, 32);
    rfsh_ack = 1'b1; cyc(); rfsh_ack = 1'b0; cyc();
    cfg_period = PW'(4); cfg_load = 1'b1; cyc(); cfg_load = 1'b0;
    chk("R2 no request from load", int'(rfsh_req), 0);
    k = 0;
    while (!rfsh_req && k < 100) begin cyc(); k++; end
    chk("R2 request after reload", k, 6);
    ack_gap(k, 100);
    chk("R2 new spacing", k, 5);
    cfg_enable = 1'b0; cyc();

    // R7, R8, R9 bus reclaim sequence (P=10)
    cfg_period = PW'(10); hold_req = 1'b1; cyc(); cyc();
    chk("R6 hold granted", int'(hold_ack), 1);
    cfg_enable = 1'b1;
    repeat (11) cyc();
    chk("R7 still granted before owed", int'(hold_ack), 1);
    cyc();
    chk("R7 grant withdrawn", int'(hold_ack), 0);
    t = 0;
    for (int i = 0; i < 5; i++) begin cyc(); t += int'(rfsh_req) + int'(hold_ack); end
    chk("R7 no request while hold high", t, 0);
    hold_req = 1'b0; cyc();
    chk("R8 not on first edge", int'(rfsh_req), 0);
    cyc();
    chk("R8 on second edge", int'(rfsh_req), 1);
    hold_req = 1'b1;
    t = 0;
    for (int i = 0; i < 3; i++) begin cyc(); t += int'(hold_ack); end
    chk("R9 no grant during refresh", t, 0);
    rfsh_ack = 1'b1; cyc(); rfsh_ack = 1'b0;
    chk("R9 ack edge: request low", int'(rfsh_req), 0);
    chk("R9 ack edge: no grant yet", int'(hold_ack), 0);
    cyc();
    chk("R9 regrant after refresh", int'(hold_ack), 1);
    hold_req = 1'b0; cfg_enable = 1'b0; cyc(); cyc();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule